// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This unit holds the modem control register of a UART and turns its contents into pin-level handshake outputs. It also routes the serial and infrared data paths and the modem status lines between the pins and the UART core. Software writes the register through a simple write strobe and can read it back. The register selects the line function (plain UART, infrared, RS485), enables automatic request-to-send flow control, enables diagnostic loopback, and sets the data-terminal-ready and request-to-send controls.

In normal operation the outputs follow the register and the pins pass through to the core, with active-low pins shown to the core as active-high status. With automatic flow control enabled and the FIFOs on, the receive FIFO threshold flag can force request-to-send inactive. In loopback the pins are parked in their idle state. Transmit data, control outputs and the two auxiliary outputs are then fed back internally to the core's receive and status inputs. For the infrared function the transmit pulse stream is fed back inverted.

Top module: `uart_modem_ctl`

## Requirements
- R1: While rst_n is low, every output takes its reset value at each clock edge: control register 0, all four active-low modem pins 1, ser_out 1, core_rx 1, ir_out 0, core_ir_rx 0, and all four core status outputs 0.
- R2: Register layout: bits 7:6 select the function (00 UART, 01 infrared, 10 RS485, 11 reserved and handled as UART), bit 5 enables auto flow control, bit 4 enables loopback, bit 1 is RTS and bit 0 is DTR. Write data in bits 3:2 and above bit 7 is dropped, and rd_data returns 0 in those positions.
- R3: Outside loopback, term_ready_n is the inverse of bit 0, and aux1_n and aux2_n are the inverses of aux1_ctl and aux2_ctl.
- R4: Outside loopback, req_send_n is the inverse of bit 1, except that it is driven 1 when bit 5, fifo_on and rxq_high are all 1. It returns low as soon as rxq_high drops while bit 1 is still 1, with no hysteresis.
- R5: rxq_high has no effect on req_send_n unless both bit 5 and fifo_on are 1.
- R6: Outside loopback, ser_out follows ser_tx, core_rx follows ser_in_pin, ir_out follows ir_tx_pulse, core_ir_rx follows ir_in_pin, and each core status output is the inverse of its pin (clr_send, set_ready, ring, carrier).
- R7: In loopback with any function other than infrared, ser_out is held 1, core_rx follows ser_tx, and ser_in_pin is ignored.
- R8: In loopback with the infrared function, ir_out is held 0, core_ir_rx is the inverse of ir_tx_pulse, and ir_in_pin is ignored. The serial path stays as in R6.
- R9: In loopback, all four active-low modem pins are held 1, the external status pins are ignored, and the core sees set_ready = bit 0, clr_send = bit 1, ring = aux1_ctl and carrier = aux2_ctl.
- R10: Every output reflects the register write and input values present at a clock edge, and changes at that edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | BUS_W | Register write data |
| rd_data | output | BUS_W | Register read-back value |
| ser_tx | input | 1 | Serial transmit stream from the core |
| ser_in_pin | input | 1 | External serial receive pin |
| ir_tx_pulse | input | 1 | Infrared transmit pulse stream from the encoder |
| ir_in_pin | input | 1 | External infrared receive pin |
| clr_send_pin_n | input | 1 | Clear-to-send pin, active low |
| set_ready_pin_n | input | 1 | Data-set-ready pin, active low |
| ring_pin_n | input | 1 | Ring indicator pin, active low |
| carrier_pin_n | input | 1 | Carrier detect pin, active low |
| aux1_ctl | input | 1 | Auxiliary output 1 control |
| aux2_ctl | input | 1 | Auxiliary output 2 control |
| fifo_on | input | 1 | FIFOs enabled |
| rxq_high | input | 1 | Receive FIFO above its threshold |
| term_ready_n | output | 1 | Data-terminal-ready pin, active low |
| req_send_n | output | 1 | Request-to-send pin, active low |
| aux1_n | output | 1 | Auxiliary output 1 pin, active low |
| aux2_n | output | 1 | Auxiliary output 2 pin, active low |
| ser_out | output | 1 | Serial transmit pin |
| ir_out | output | 1 | Infrared transmit pin |
| core_rx | output | 1 | Serial receive data to the core |
| core_ir_rx | output | 1 | Infrared receive data to the decoder |
| clr_send | output | 1 | Clear-to-send status to the core |
| set_ready | output | 1 | Data-set-ready status to the core |
| ring | output | 1 | Ring status to the core |
| carrier | output | 1 | Carrier status to the core |

## Verification
The bench builds the unit with its default bus width of 32 bits. At that width, writes that set bits 31:8 and 3:2 test that those bits are dropped and read back as zero. Directed writes cover every function code with loopback on and off, and every combination of auto flow enable, FIFO enable and threshold flag. A long run of random writes and random pin values then crosses function, loopback and flow control settings with changing pins in the same cycle.

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl #(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  input  logic             ser_tx,
  input  logic             ser_in_pin,
  input  logic             ir_tx_pulse,
  input  logic             ir_in_pin,
  input  logic             clr_send_pin_n,
  input  logic             set_ready_pin_n,
  input  logic             ring_pin_n,
  input  logic             carrier_pin_n,
  input  logic             aux1_ctl,
  input  logic             aux2_ctl,
  input  logic             fifo_on,
  input  logic             rxq_high,
  output logic             term_ready_n,
  output logic             req_send_n,
  output logic             aux1_n,
  output logic             aux2_n,
  output logic             ser_out,
  output logic             ir_out,
  output logic             core_rx,
  output logic             core_ir_rx,
  output logic             clr_send,
  output logic             set_ready,
  output logic             ring,
  output logic             carrier
);

  localparam int          CTL_W    = 8;
  localparam logic [7:0]  CTL_MASK = 8'hF3;
  localparam logic [1:0]  FN_IR    = 2'b01;

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             lb, ir_fn, auto_rts;

  assign ctl_d    = wr_en ? (wr_data[CTL_W-1:0] & CTL_MASK) : ctl_q;
  assign lb       = ctl_d[4];
  assign ir_fn    = (ctl_d[7:6] == FN_IR);
  assign auto_rts = ctl_d[5] & fifo_on;
  assign rd_data  = {{(BUS_W-CTL_W){1'b0}}, ctl_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      term_ready_n <= 1'b1;
      req_send_n   <= 1'b1;
      aux1_n       <= 1'b1;
      aux2_n       <= 1'b1;
      ser_out      <= 1'b1;
      ir_out       <= 1'b0;
      core_rx      <= 1'b1;
      core_ir_rx   <= 1'b0;
      clr_send     <= 1'b0;
      set_ready    <= 1'b0;
      ring         <= 1'b0;
      carrier      <= 1'b0;
    end else begin
      ctl_q        <= ctl_d;
      term_ready_n <= lb | ~ctl_d[0];
      req_send_n   <= lb | ~ctl_d[1] | (auto_rts & rxq_high);
      aux1_n       <= lb | ~aux1_ctl;
      aux2_n       <= lb | ~aux2_ctl;
      ser_out      <= (lb & ~ir_fn) | ser_tx;
      core_rx      <= (lb & ~ir_fn) ? ser_tx : ser_in_pin;
      ir_out       <= ~(lb & ir_fn) & ir_tx_pulse;
      core_ir_rx   <= (lb & ir_fn) ? ~ir_tx_pulse : ir_in_pin;
      set_ready    <= lb ? ctl_d[0] : ~set_ready_pin_n;
      clr_send     <= lb ? ctl_d[1] : ~clr_send_pin_n;
      ring         <= lb ? aux1_ctl : ~ring_pin_n;
      carrier      <= lb ? aux2_ctl : ~carrier_pin_n;
    end
  end

  a_r4_thresh_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctl_q[5] && fifo_on && rxq_high) |=> req_send_n);

  a_r5_no_gate_without_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ctl_q[4] && ctl_q[1] && !(ctl_q[5] && fifo_on)) |=> !req_send_n);

  a_r7_serial_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctl_q[4] && ctl_q[7:6] != FN_IR) |=> (ser_out && core_rx == $past(ser_tx)));

  a_r8_ir_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctl_q[4] && ctl_q[7:6] == FN_IR) |=> (!ir_out && core_ir_rx == !$past(ir_tx_pulse)));

  a_r9_pins_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctl_q[4]) |=> (term_ready_n && req_send_n && aux1_n && aux2_n));

  a_r9_status_fed_back: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctl_q[4]) |=> (set_ready == $past(ctl_q[0]) && clr_send == $past(ctl_q[1])));

endmodule

// File: tb/uart_modem_ctl_tb.sv
`timescale 1ns/1ps
module uart_modem_ctl_tb;
  localparam int BUS_W = 32;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [BUS_W-1:0] wr_data = '0, rd_data;
  logic ser_tx = 1, ser_in_pin = 1, ir_tx_pulse = 0, ir_in_pin = 0;
  logic clr_send_pin_n = 1, set_ready_pin_n = 1, ring_pin_n = 1, carrier_pin_n = 1;
  logic aux1_ctl = 0, aux2_ctl = 0, fifo_on = 0, rxq_high = 0;
  logic term_ready_n, req_send_n, aux1_n, aux2_n, ser_out, ir_out;
  logic core_rx, core_ir_rx, clr_send, set_ready, ring, carrier;

  int checks = 0, errors = 0;
  int m_ctl = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_modem_ctl #(.BUS_W(BUS_W)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    bit lb, irf, gate;
    @(posedge clk); #1;
    if (!rst_n) begin
      m_ctl = 0;
      chk("R1 rd_data", rd_data, 0);
      chk("R1 pins", {term_ready_n, req_send_n, aux1_n, aux2_n}, 4'hF);
      chk("R1 data", {ser_out, core_rx, ir_out, core_ir_rx}, 4'b1100);
      chk("R1 status", {clr_send, set_ready, ring, carrier}, 0);
      return;
    end
    if (wr_en) m_ctl = wr_data & 32'hF3;
    lb   = m_ctl[4];
    irf  = (m_ctl[7:6] == 2'b01);
    gate = m_ctl[5] && fifo_on && rxq_high;
    chk("R2 R10 rd_data", rd_data, m_ctl);
    if (lb) begin
      chk("R9 pins parked", {term_ready_n, req_send_n, aux1_n, aux2_n}, 4'hF);
      chk("R9 set_ready/clr_send", {set_ready, clr_send}, {m_ctl[0], m_ctl[1]});
      chk("R9 ring/carrier", {ring, carrier}, {aux1_ctl, aux2_ctl});
    end else begin
      chk("R3 term_ready_n", term_ready_n, !m_ctl[0]);
      chk("R3 aux", {aux1_n, aux2_n}, {!aux1_ctl, !aux2_ctl});
      if (gate) chk("R4 req_send_n gated", req_send_n, 1);
      else      chk("R5 req_send_n", req_send_n, !m_ctl[1]);
      chk("R6 status", {clr_send, set_ready, ring, carrier},
          {!clr_send_pin_n, !set_ready_pin_n, !ring_pin_n, !carrier_pin_n});
    end
    if (lb && !irf) chk("R7 serial loop", {ser_out, core_rx}, {1'b1, ser_tx});
    else            chk("R6 serial path", {ser_out, core_rx}, {ser_tx, ser_in_pin});
    if (lb && irf)  chk("R8 ir loop", {ir_out, core_ir_rx}, {1'b0, !ir_tx_pulse});
    else            chk("R6 ir path", {ir_out, core_ir_rx}, {ir_tx_pulse, ir_in_pin});
  endtask

  task automatic wr(int v);
    wr_en = 1; wr_data = v; cyc(); wr_en = 0; wr_data = '0;
  endtask

  task automatic pins(int v);
    {ser_tx, ser_in_pin, ir_tx_pulse, ir_in_pin, clr_send_pin_n, set_ready_pin_n,
     ring_pin_n, carrier_pin_n, aux1_ctl, aux2_ctl} = v[9:0];
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1;
    cyc();
    // R2: upper and unused bits dropped
    wr(32'hFFFF_FF0F); cyc();
    chk("R2 masked readback", rd_data, 32'h03);
    wr(32'h0000_0001);
    // R4/R5 flag combinations with RTS set
    wr(32'h0000_0022);
    for (int k = 0; k < 4; k++) begin
      fifo_on = k[0]; rxq_high = k[1]; cyc(); cyc();
    end
    // R4 no hysteresis: flag drops, pin re-asserts next edge
    fifo_on = 1; rxq_high = 1; cyc();
    rxq_high = 0; cyc();
    chk("R4 reassert", req_send_n, 0);
    wr(32'h0000_0002); rxq_high = 1; cyc();
    chk("R5 no auto", req_send_n, 0);
    rxq_high = 0;
    // R10: write visible at the same edge only
    wr_en = 1; wr_data = 32'h01; #1;
    chk("R10 before edge", term_ready_n, 1);
    cyc(); wr_en = 0;
    // loopback in every function
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 8; v++) begin
        wr((f << 6) | 32'h10 | (v & 3));
        pins(v * 37 + f); cyc();
        pins(~(v * 37 + f)); cyc();
      end
    end
    // random crossing
    for (int n = 0; n < 4000; n++) begin
      pins($urandom);
      fifo_on = $urandom; rxq_high = $urandom;
      if ($urandom_range(0, 3) == 0) begin wr_en = 1; wr_data = $urandom; end
      cyc();
      wr_en = 0;
    end
    // R1 again after activity
    rst_n = 0; cyc(); rst_n = 1; cyc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule